// File: doc/BRIEF.md
# Branch Decision Unit

This block settles the control-flow outcome of one branch-class instruction of a small 8-bit accumulator machine. It is given a branch class, the accumulator, one selected bit, a working-register byte, an immediate byte, a target and the current program counter with the instruction length. One clock later it returns whether the branch was taken and the next program counter. Some classes also have a side effect, and the block returns that as well: a register write-back or a carry update.

The block fuses condition testing with those side effects. Decrement-and-branch reduces the register, hands back the new value for write-back, and tests that new value. Compare-and-branch tests for inequality and also produces a carry that reports unsigned less-than. Subroutine call and return use a small internal stack of return addresses. When that stack is misused, a sticky fault flag is raised.

Top module: `bdu_core`

## Requirements
- R1: A request presented with `valid_i` high produces exactly one result, with `valid_o` high, on the following clock. Its target is `tgt_i` when `rel_i` is 0. When `rel_i` is 1, the target is `pc_i + len_i` plus the sign-extended low byte of `tgt_i`. Class 0 (jump) is always taken to that target.
- R2: Class 1 is taken only when `acc_i` is 0x00. Class 2 is taken only when `acc_i` is not 0x00.
- R3: Class 3 is taken when `bit_i` is 1. Class 4 is taken when `bit_i` is 0.
- R4: A request that is not taken gives `npc_o = pc_i + len_i` with `taken_o` low. A taken request gives `taken_o` high.
- R5: Class 5 returns `reg_i - 1` on `wb_o`, with `wb_en_o` high and 0x00 wrapping to 0xFF. The branch is taken when that new value is not zero.
- R6: Class 6 is taken when `reg_i` differs from `imm_i`. It sets `cy_en_o` high, with `cy_o` = 1 exactly when `reg_i < imm_i` unsigned. It never asserts `wb_en_o`.
- R7: Class 7 (call) pushes `pc_i + len_i` and is taken to the target. Class 8 (return) pops the most recent entry and is taken to it, in last-in first-out order.
- R8: The stack holds DEPTH (8) entries. A call made while the stack is full still jumps, but the push is dropped and `err_o` is raised. A return made while the stack is empty is not taken and raises `err_o`. `err_o` stays high until reset.
- R9: After reset, `valid_o`, `taken_o`, `wb_en_o`, `cy_en_o` and `err_o` are all 0.
- R10: Classes 9 to 15 are never taken, write nothing, update no carry and leave the stack unchanged. Outside the classes named, `wb_en_o`, `wb_o`, `cy_en_o` and `cy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | Request present |
| op_i | input | 4 | Branch class |
| acc_i | input | 8 | Accumulator value |
| bit_i | input | 1 | Selected bit value |
| reg_i | input | 8 | Working-register value |
| imm_i | input | 8 | Immediate byte |
| rel_i | input | 1 | Target is relative offset |
| tgt_i | input | 16 | Absolute target or offset in low byte |
| pc_i | input | 16 | Current program counter |
| len_i | input | 3 | Instruction length in bytes |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Branch taken |
| npc_o | output | 16 | Next program counter |
| wb_en_o | output | 1 | Register write-back enable |
| wb_o | output | 8 | Register write-back value |
| cy_en_o | output | 1 | Carry update enable |
| cy_o | output | 1 | New carry value |
| err_o | output | 1 | Sticky stack fault |

## Verification
The bench drives decrement-and-branch with registers of 1 and 0. A design that tested the old value would take the first and skip the second, and one without wraparound would write 0x00 instead of 0xFF. Compare-and-branch is run with an equal operand, a smaller operand and a larger operand, which separates an inverted or signed carry from a correct one. A relative jump with a negative offset catches a missing sign extension. Nested calls are followed by nine returns after a ninth call, which exposes a stack that wraps, loses LIFO order, or fails to report the dropped push and the empty pop. An unused class placed between a call and its return would show up as a wrong return address if it disturbed the stack.

// File: rtl/bdu_core.sv
module bdu_core #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic          bit_i,
  input  logic [DW-1:0] reg_i,
  input  logic [DW-1:0] imm_i,
  input  logic          rel_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [AW-1:0] pc_i,
  input  logic [LW-1:0] len_i,
  output logic          valid_o,
  output logic          taken_o,
  output logic [AW-1:0] npc_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_o,
  output logic          cy_en_o,
  output logic          cy_o,
  output logic          err_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [3:0] C_JMP = 4'd0, C_JZ = 4'd1, C_JNZ = 4'd2, C_JB = 4'd3,
                         C_JNB = 4'd4, C_DJNZ = 4'd5, C_CJNE = 4'd6,
                         C_CALL = 4'd7, C_RET = 4'd8;

  logic [AW-1:0] stk [DEPTH];
  logic [SPW-1:0] sp;

  logic [AW-1:0] seq, dest, top, npc_n;
  logic [DW-1:0] dec;
  logic [IW-1:0] wr_idx, rd_idx;
  logic full, empty, take, wbe, cye, cyv, push, pop, fault;

  assign seq    = pc_i + AW'(len_i);
  assign dest   = rel_i ? seq + {{(AW-DW){tgt_i[DW-1]}}, tgt_i[DW-1:0]} : tgt_i;
  assign dec    = reg_i - 1'b1;
  assign full   = (sp == SPW'(DEPTH));
  assign empty  = (sp == '0);
  assign wr_idx = IW'(sp);
  assign rd_idx = IW'(sp - 1'b1);
  assign top    = stk[rd_idx];

  always_comb begin
    take = 1'b0; wbe = 1'b0; cye = 1'b0; cyv = 1'b0;
    push = 1'b0; pop = 1'b0; fault = 1'b0;
    unique case (op_i)
      C_JMP:  take = 1'b1;
      C_JZ:   take = (acc_i == '0);
      C_JNZ:  take = (acc_i != '0);
      C_JB:   take = bit_i;
      C_JNB:  take = !bit_i;
      C_DJNZ: begin wbe = 1'b1; take = (dec != '0); end
      C_CJNE: begin cye = 1'b1; cyv = (reg_i < imm_i); take = (reg_i != imm_i); end
      C_CALL: begin take = 1'b1; push = !full; fault = full; end
      C_RET:  begin take = !empty; pop = !empty; fault = empty; end
      default: ;
    endcase
  end

  assign npc_n = !take ? seq : (op_i == C_RET) ? top : dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0; taken_o <= 1'b0; npc_o <= '0;
      wb_en_o <= 1'b0; wb_o <= '0; cy_en_o <= 1'b0; cy_o <= 1'b0;
      err_o <= 1'b0; sp <= '0;
    end else begin
      valid_o <= valid_i;
      taken_o <= valid_i && take;
      npc_o   <= valid_i ? npc_n : npc_o;
      wb_en_o <= valid_i && wbe;
      wb_o    <= (valid_i && wbe) ? dec : '0;
      cy_en_o <= valid_i && cye;
      cy_o    <= valid_i && cyv;
      if (valid_i && fault) err_o <= 1'b1;
      if (valid_i && push) sp <= sp + 1'b1;
      else if (valid_i && pop) sp <= sp - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (valid_i && push) stk[wr_idx] <= seq;
  end
endmodule

module bdu_core_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic          bit_i,
  input logic [DW-1:0] reg_i,
  input logic [DW-1:0] imm_i,
  input logic          rel_i,
  input logic [AW-1:0] tgt_i,
  input logic          valid_o,
  input logic          taken_o,
  input logic [AW-1:0] npc_o,
  input logic          wb_en_o,
  input logic [DW-1:0] wb_o,
  input logic          cy_en_o,
  input logic          cy_o,
  input logic          err_o
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o); // R1
  AST_JMP_ABS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd0 && !rel_i) |=> (taken_o && npc_o == $past(tgt_i))); // R1
  AST_ZERO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd1) |=> (taken_o == ($past(acc_i) == '0))); // R2
  AST_BIT_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd3) |=> (taken_o == $past(bit_i))); // R3
  AST_DEC_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd5) |=> (wb_en_o && wb_o == DW'($past(reg_i) - 1'b1))); // R5
  AST_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 4'd6) |=> (!wb_en_o && cy_en_o && cy_o == ($past(reg_i) < $past(imm_i)))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R8
  AST_UNUSED_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i > 4'd8) |=> (!taken_o && !wb_en_o && !cy_en_o)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && !taken_o && !wb_en_o && !cy_en_o)); // R1
endmodule

bind bdu_core bdu_core_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .acc_i(acc_i),
  .bit_i(bit_i), .reg_i(reg_i), .imm_i(imm_i), .rel_i(rel_i), .tgt_i(tgt_i),
  .valid_o(valid_o), .taken_o(taken_o), .npc_o(npc_o), .wb_en_o(wb_en_o),
  .wb_o(wb_o), .cy_en_o(cy_en_o), .cy_o(cy_o), .err_o(err_o));

// File: tb/sim_bdu_core.sv
module sim_bdu_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, bit_i = 1'b0, rel_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, reg_i = '0, imm_i = '0;
  logic [15:0] tgt_i = '0, pc_i = '0;
  logic [2:0] len_i = '0;
  logic valid_o, taken_o, wb_en_o, cy_en_o, cy_o, err_o;
  logic [15:0] npc_o;
  logic [7:0] wb_o;

  typedef struct {
    string tag; logic taken; logic [15:0] npc; logic wbe; logic [7:0] wb;
    logic cye; logic cy; logic err;
  } item_t;
  item_t sb[$];
  logic [15:0] mstk[$];
  logic merr = 1'b0;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bdu_core u0 (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .acc_i(acc_i), .bit_i(bit_i), .reg_i(reg_i), .imm_i(imm_i), .rel_i(rel_i),
    .tgt_i(tgt_i), .pc_i(pc_i), .len_i(len_i), .valid_o(valid_o),
    .taken_o(taken_o), .npc_o(npc_o), .wb_en_o(wb_en_o), .wb_o(wb_o),
    .cy_en_o(cy_en_o), .cy_o(cy_o), .err_o(err_o));

  task automatic drive(string tag, logic [3:0] op, logic [7:0] acc, logic b,
                       logic [7:0] rg, logic [7:0] im, logic rel,
                       logic [15:0] tg, logic [15:0] pc, logic [2:0] ln);
    item_t e;
    logic [15:0] seq, dst;
    seq = pc + 16'(ln);
    dst = rel ? seq + {{8{tg[7]}}, tg[7:0]} : tg;
    e.tag = tag; e.taken = 0; e.npc = seq; e.wbe = 0; e.wb = 0; e.cye = 0; e.cy = 0;
    case (op)
      4'd0: e.taken = 1;
      4'd1: e.taken = (acc == 0);
      4'd2: e.taken = (acc != 0);
      4'd3: e.taken = b;
      4'd4: e.taken = !b;
      4'd5: begin e.wbe = 1; e.wb = rg - 8'd1; e.taken = (e.wb != 0); end
      4'd6: begin e.cye = 1; e.cy = (rg < im); e.taken = (rg != im); end
      4'd7: begin e.taken = 1; if (mstk.size() == 8) merr = 1; else mstk.push_back(seq); end
      4'd8: if (mstk.size() == 0) merr = 1; else begin e.taken = 1; e.npc = mstk.pop_back(); end
      default: ;
    endcase
    if (e.taken && op != 4'd8) e.npc = dst;
    e.err = merr;
    @(negedge clk);
    valid_i = 1; op_i = op; acc_i = acc; bit_i = b; reg_i = rg; imm_i = im;
    rel_i = rel; tgt_i = tg; pc_i = pc; len_i = ln;
    sb.push_back(e);
    @(negedge clk);
    valid_i = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && valid_o) begin
      item_t e;
      tests++;
      if (sb.size() == 0) begin
        fails++; $display("FAIL R1 unexpected result actual=valid expected=none");
      end else begin
        e = sb.pop_front();
        if (taken_o !== e.taken || npc_o !== e.npc || wb_en_o !== e.wbe || wb_o !== e.wb ||
            cy_en_o !== e.cye || cy_o !== e.cy || err_o !== e.err) begin
          fails++;
          $display("FAIL %s actual=t%0b pc%h we%0b w%h ce%0b c%0b e%0b expected=t%0b pc%h we%0b w%h ce%0b c%0b e%0b",
            e.tag, taken_o, npc_o, wb_en_o, wb_o, cy_en_o, cy_o, err_o,
            e.taken, e.npc, e.wbe, e.wb, e.cye, e.cy, e.err);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    tests++;
    if ({valid_o, taken_o, wb_en_o, cy_en_o, err_o} !== 5'b0) begin
      fails++; $display("FAIL R9 reset actual=%b expected=00000", {valid_o, taken_o, wb_en_o, cy_en_o, err_o});
    end
    @(negedge clk); rst_n = 1;
    drive("R1 jmp abs", 0, 8'h55, 0, 0, 0, 0, 16'h1234, 16'h0100, 3);
    drive("R1 jmp rel fwd", 0, 0, 0, 0, 0, 1, 16'h0010, 16'h0200, 2);
    drive("R1 jmp rel back", 0, 0, 0, 0, 0, 1, 16'h00F0, 16'h0200, 2);
    drive("R2 jz zero", 1, 8'h00, 0, 0, 0, 0, 16'h0400, 16'h0300, 2);
    drive("R2 jz nonzero R4", 1, 8'h05, 0, 0, 0, 0, 16'h0400, 16'h0300, 2);
    drive("R2 jnz nonzero", 2, 8'h80, 0, 0, 0, 0, 16'h0500, 16'h0300, 2);
    drive("R2 jnz zero R4", 2, 8'h00, 0, 0, 0, 0, 16'h0500, 16'h0300, 2);
    drive("R3 jb set", 3, 0, 1, 0, 0, 0, 16'h0600, 16'h0310, 3);
    drive("R3 jb clear", 3, 0, 0, 0, 0, 0, 16'h0600, 16'h0310, 3);
    drive("R3 jnb clear", 4, 0, 0, 0, 0, 0, 16'h0700, 16'h0310, 3);
    drive("R3 jnb set", 4, 0, 1, 0, 0, 0, 16'h0700, 16'h0310, 3);
    drive("R5 djnz 3", 5, 0, 0, 8'h03, 0, 1, 16'h00FC, 16'h0800, 2);
    drive("R5 djnz 1", 5, 0, 0, 8'h01, 0, 1, 16'h00FC, 16'h0800, 2);
    drive("R5 djnz wrap", 5, 0, 0, 8'h00, 0, 1, 16'h00FC, 16'h0800, 2);
    drive("R6 cjne equal", 6, 0, 0, 8'h40, 8'h40, 1, 16'h0020, 16'h0900, 3);
    drive("R6 cjne less", 6, 0, 0, 8'h10, 8'h40, 1, 16'h0020, 16'h0900, 3);
    drive("R6 cjne greater", 6, 0, 0, 8'hF0, 8'h40, 1, 16'h0020, 16'h0900, 3);
    drive("R10 unused 9", 9, 0, 1, 8'h12, 8'h34, 0, 16'hABCD, 16'h0A00, 1);
    drive("R10 unused 15", 15, 0, 1, 8'h00, 8'h34, 0, 16'hABCD, 16'h0A00, 1);
    drive("R7 call a", 7, 0, 0, 0, 0, 0, 16'h2000, 16'h1000, 3);
    drive("R7 call b", 7, 0, 0, 0, 0, 0, 16'h3000, 16'h2010, 3);
    drive("R10 unused between", 12, 0, 0, 8'h01, 0, 0, 16'h4444, 16'h3000, 1);
    drive("R7 ret b", 8, 0, 0, 0, 0, 0, 0, 16'h3008, 1);
    drive("R7 ret a", 8, 0, 0, 0, 0, 0, 0, 16'h2020, 1);
    for (int i = 0; i < 9; i++)
      drive("R8 call fill", 7, 0, 0, 0, 0, 0, 16'h5000 + 16'(i * 16), 16'h4000 + 16'(i * 16), 3);
    for (int i = 0; i < 9; i++)
      drive("R8 ret drain", 8, 0, 0, 0, 0, 0, 0, 16'h6000, 1);
    drive("R8 err sticky", 0, 0, 0, 0, 0, 0, 16'h0000, 16'h7000, 1);
    repeat (4) @(negedge clk);
    tests++;
    if (sb.size() != 0) begin
      fails++; $display("FAIL R1 missing results actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule